// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block sequences a small in-order pipeline that holds several hardware thread contexts and issues from only one of them at a time. The running thread keeps the pipeline until the datapath reports an expensive event, such as a last-level cache miss. On that event the controller parks the thread, stores the address of the instruction that missed as the thread's resume point, and drains the pipeline with a one-cycle flush. It then loads the program counter of the next runnable thread. Short stalls only freeze the fetch address and never cause a switch.

Each switch has a visible cost. The new thread spends a fixed refill window, equal to the pipeline depth, before any of its instructions may complete. A further expensive-event report is not accepted until that window has ended. A parked thread becomes runnable again when the memory side returns its miss, identified by thread number. Threads can also be excluded from selection by an enable mask. When no thread is runnable, the pipeline receives bubbles until one becomes runnable.

The cache, instruction memory, register files and datapath are outside this block. Per-thread program counter storage is inside it.

Top module: `cgmt_switch_ctl`

## Requirements
- R1: While and after reset, fetch_vld_o, flush_o and refill_o are 0. The saved resume address of thread i is BOOT_BASE + i*BOOT_STEP (0x1000 + 0x100*i by default).
- R2: A miss_i that is accepted (fetch_vld_o=1, refill_o=0) makes flush_o 1 for exactly the next cycle and moves execution away from the running thread. flush_o is never 1 at any other time.
- R3: After a thread starts, refill_o is 1 for exactly DEPTH (4) cycles, beginning in the first cycle that shows the new thread. A miss_i during those cycles is ignored.
- R4: On an accepted miss, the running thread's resume address becomes miss_pc_i. A thread that starts shows its resume address on fetch_pc_o in its first cycle. Each later cycle without stall_i adds PC_INC (4).
- R5: stall_i holds fetch_pc_o for one cycle and never changes tid_o.
- R6: The next thread is searched in the order tid_o+1, tid_o+2, … modulo NTHR, with the current tid_o last. It is the first thread that is enabled and not parked. From reset (tid_o=0), thread 1 is tried first.
- R7: If no thread is eligible, fetch_vld_o is 0 (bubbles). When one becomes eligible, it starts the next cycle with flush_o=0.
- R8: An accepted miss parks the running thread. ret_i with ret_tid_i unparks that thread, which can be selected in the same cycle. A miss and a return for the running thread in the same cycle leave it parked. A return for an unparked thread has no effect.
- R9: A thread whose thr_en_i bit is 0 is never selected. The bit has no effect on a thread that is already running.
- R10: Only one thread issues at a time. tid_o changes only in a cycle where a new thread starts, which shows refill_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en_i | input | NTHR | Per-thread eligibility mask |
| stall_i | input | 1 | Short stall; holds the fetch address |
| miss_i | input | 1 | Expensive event on the running thread |
| miss_pc_i | input | PC_W | Address of the instruction that missed |
| ret_i | input | 1 | Miss return strobe |
| ret_tid_i | input | TID_W | Thread whose miss returned |
| fetch_vld_o | output | 1 | A thread is issuing this cycle |
| tid_o | output | TID_W | Selected thread |
| fetch_pc_o | output | PC_W | Fetch address of the selected thread |
| flush_o | output | 1 | Drain in-flight instructions of the old thread |
| refill_o | output | 1 | New thread is refilling the pipeline |

## Verification
Every output is registered, so each response to an input sampled at a rising edge is due in the cycle that follows that edge. The refill window then stays high for DEPTH further cycles counted from that first cycle. The bench drives inputs at the falling edge and advances a behavioural model on the same rising edge as the design. It compares every output at the next falling edge, so each check samples exactly one cycle after its stimulus. Directed checks with hand-computed values cover the start from reset, the ignored miss during refill, a park with the enable mask set and a simultaneous return, resume at the missed address, and the all-parked bubble case. Several thousand cycles of pseudo-random stimulus follow.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;

  // What the controller does with the pipeline in a given cycle
  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,  // keep issuing the current thread
    ACT_START = 2'd1,  // begin a thread and open a refill window
    ACT_PARK  = 2'd2,  // accepted miss but nobody is eligible
    ACT_IDLE  = 2'd3   // pipeline empty, still nobody eligible
  } ctl_act_e;

endpackage

// File: rtl/cgmt_wait_track.sv
module cgmt_wait_track #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TID_W-1:0] set_tid,
  input  logic             clr_en,
  input  logic [TID_W-1:0] clr_tid,
  output logic [NTHR-1:0]  wait_q,
  output logic [NTHR-1:0]  wait_nx
);

  logic [NTHR-1:0] set_vec;
  logic [NTHR-1:0] clr_vec;

  assign set_vec = set_en ? (NTHR'(1) << set_tid) : '0;
  assign clr_vec = clr_en ? (NTHR'(1) << clr_tid) : '0;
  // A park request wins over a return for the same thread
  assign wait_nx = (wait_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) wait_q <= '0;
    else     wait_q <= wait_nx;
  end

  AST_PARK_WINS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> wait_q[$past(set_tid)]); // R8

endmodule

// File: rtl/cgmt_rr_pick.sv
module cgmt_rr_pick #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic [NTHR-1:0]  cand,
  input  logic [TID_W-1:0] base,
  output logic             found,
  output logic [TID_W-1:0] sel
);

  // Search base+1 .. base+NTHR; the loop runs backwards so the nearest wins
  always_comb begin
    int idx;
    found = 1'b0;
    sel   = base;
    idx   = 0;
    for (int k = NTHR; k >= 1; k--) begin
      idx = int'(base) + k;
      if (idx >= NTHR) idx = idx - NTHR;
      if (cand[TID_W'(idx)]) begin
        found = 1'b1;
        sel   = TID_W'(idx);
      end
    end
  end

  always_comb begin
    if (found) AST_PICK_LEGAL: assert (cand[sel]); // R6
  end

endmodule

// File: rtl/cgmt_pc_store.sv
module cgmt_pc_store #(
  parameter int                NTHR      = 4,
  parameter int                TID_W     = 2,
  parameter int                PC_W      = 32,
  parameter logic [PC_W-1:0]   BOOT_BASE = 'h1000,
  parameter logic [PC_W-1:0]   BOOT_STEP = 'h100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [TID_W-1:0] rd_tid,
  output logic [PC_W-1:0]  rd_pc
);

  logic [PC_W-1:0] mem_q [NTHR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTHR; i++)
        mem_q[i] <= BOOT_BASE + PC_W'(i) * BOOT_STEP;
    end else if (wr_en) begin
      mem_q[wr_tid] <= wr_pc;
    end
  end

  assign rd_pc = mem_q[rd_tid];

  AST_SAVE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem_q[$past(wr_tid)] == $past(wr_pc))); // R4

endmodule

// File: rtl/cgmt_switch_ctl.sv
module cgmt_switch_ctl
  import cgmt_pkg::*;
#(
  parameter int              NTHR      = 4,
  parameter int              PC_W      = 32,
  parameter int              DEPTH     = 4,
  parameter int              PC_INC    = 4,
  parameter logic [PC_W-1:0] BOOT_BASE = 'h1000,
  parameter logic [PC_W-1:0] BOOT_STEP = 'h100,
  localparam int             TID_W     = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTHR-1:0]  thr_en_i,
  input  logic             stall_i,
  input  logic             miss_i,
  input  logic [PC_W-1:0]  miss_pc_i,
  input  logic             ret_i,
  input  logic [TID_W-1:0] ret_tid_i,
  output logic             fetch_vld_o,
  output logic [TID_W-1:0] tid_o,
  output logic [PC_W-1:0]  fetch_pc_o,
  output logic             flush_o,
  output logic             refill_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take_miss;
  logic             need_pick;
  logic [NTHR-1:0]  wait_q;
  logic [NTHR-1:0]  wait_nx;
  logic [NTHR-1:0]  cand;
  logic             found;
  logic [TID_W-1:0] sel;
  logic [PC_W-1:0]  sel_pc;
  ctl_act_e         act;

  assign refill_o  = (cnt_q != '0);
  assign take_miss = fetch_vld_o & ~refill_o & miss_i;
  assign need_pick = take_miss | ~fetch_vld_o;

  cgmt_wait_track #(.NTHR(NTHR), .TID_W(TID_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .set_en  (take_miss),
    .set_tid (tid_o),
    .clr_en  (ret_i),
    .clr_tid (ret_tid_i),
    .wait_q  (wait_q),
    .wait_nx (wait_nx)
  );

  assign cand = thr_en_i & ~wait_nx;

  cgmt_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
    .cand  (cand),
    .base  (tid_o),
    .found (found),
    .sel   (sel)
  );

  cgmt_pc_store #(
    .NTHR(NTHR), .TID_W(TID_W), .PC_W(PC_W),
    .BOOT_BASE(BOOT_BASE), .BOOT_STEP(BOOT_STEP)
  ) u_pcs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (take_miss),
    .wr_tid (tid_o),
    .wr_pc  (miss_pc_i),
    .rd_tid (sel),
    .rd_pc  (sel_pc)
  );

  always_comb begin
    if (!need_pick)     act = ACT_RUN;
    else if (found)     act = ACT_START;
    else if (take_miss) act = ACT_PARK;
    else                act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_vld_o <= 1'b0;
      tid_o       <= '0;
      fetch_pc_o  <= '0;
      flush_o     <= 1'b0;
      cnt_q       <= '0;
    end else begin
      unique case (act)
        ACT_START: begin
          fetch_vld_o <= 1'b1;
          tid_o       <= sel;
          fetch_pc_o  <= sel_pc;
          flush_o     <= take_miss;
          cnt_q       <= CNT_W'(DEPTH);
        end
        ACT_PARK: begin
          fetch_vld_o <= 1'b0;
          flush_o     <= 1'b1;
          cnt_q       <= '0;
        end
        ACT_IDLE: begin
          flush_o <= 1'b0;
          cnt_q   <= '0;
        end
        default: begin
          flush_o <= 1'b0;
          if (refill_o) cnt_q <= cnt_q - 1'b1;
          if (!stall_i) fetch_pc_o <= fetch_pc_o + PC_W'(PC_INC);
        end
      endcase
    end
  end

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> $past(miss_i)); // R2

  AST_PARKED_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
    fetch_vld_o |-> !wait_q[tid_o]); // R8

  AST_REFILL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (refill_o && $past(refill_o)) |-> $stable(tid_o)); // R3

  AST_SHORT_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld_o && $past(fetch_vld_o) && $past(stall_i) && !flush_o && $stable(tid_o))
      |-> $stable(fetch_pc_o)); // R5

  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(tid_o) |-> refill_o); // R10

endmodule

// File: tb/cgmt_switch_ctl_tb_top.sv
`timescale 1ns/1ps
module cgmt_switch_ctl_tb_top;

  localparam int N     = 4;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  thr_en_i = 4'b1111;
  logic        stall_i = 1'b0, miss_i = 1'b0, ret_i = 1'b0;
  logic [31:0] miss_pc_i = '0;
  logic [1:0]  ret_tid_i = '0;
  logic        fetch_vld_o, flush_o, refill_o;
  logic [1:0]  tid_o;
  logic [31:0] fetch_pc_o;

  int n_chk = 0, n_err = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cgmt_switch_ctl dut_i (
    .clk(clk), .rst(rst), .thr_en_i(thr_en_i), .stall_i(stall_i),
    .miss_i(miss_i), .miss_pc_i(miss_pc_i), .ret_i(ret_i), .ret_tid_i(ret_tid_i),
    .fetch_vld_o(fetch_vld_o), .tid_o(tid_o), .fetch_pc_o(fetch_pc_o),
    .flush_o(flush_o), .refill_o(refill_o)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on the same rising edge as the design
  bit          m_vld, m_flush;
  int          m_tid, m_cnt;
  logic [31:0] m_pc;
  bit          m_park [N];
  logic [31:0] m_save [N];

  always @(posedge clk) begin
    if (rst) begin
      m_vld = 0; m_flush = 0; m_tid = 0; m_cnt = 0; m_pc = '0;
      for (int i = 0; i < N; i++) begin
        m_park[i] = 0;
        m_save[i] = 32'h1000 + 32'(i) * 32'h100;
      end
    end else begin
      bit take, hit;
      int pick;
      take = m_vld && (m_cnt == 0) && miss_i;
      if (ret_i) m_park[ret_tid_i] = 0;
      if (take) begin
        m_park[m_tid] = 1;
        m_save[m_tid] = miss_pc_i;
      end
      if (take || !m_vld) begin
        hit = 0; pick = 0;
        for (int k = 1; k <= N; k++) begin
          int t;
          t = (m_tid + k) % N;
          if (!hit && thr_en_i[t] && !m_park[t]) begin hit = 1; pick = t; end
        end
        m_flush = take;
        if (hit) begin
          m_vld = 1; m_tid = pick; m_pc = m_save[pick]; m_cnt = DEPTH;
        end else begin
          m_vld = 0; m_cnt = 0;
        end
      end else begin
        m_flush = 0;
        if (m_cnt > 0) m_cnt--;
        if (!stall_i) m_pc = m_pc + 32'd4;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      ck("R6 R7 R9 fetch_vld", 32'(fetch_vld_o), 32'(m_vld));
      ck("R2 R7 flush", 32'(flush_o), 32'(m_flush));
      ck("R3 refill", 32'(refill_o), 32'(m_cnt != 0));
      if (m_vld) begin
        ck("R6 R8 R10 tid", 32'(tid_o), 32'(m_tid));
        ck("R4 R5 fetch_pc", fetch_pc_o, m_pc);
      end
    end
  end

  task automatic step(input bit st, input bit ms, input logic [31:0] mpc,
                      input bit rt, input logic [1:0] rtid);
    stall_i = st; miss_i = ms; miss_pc_i = mpc; ret_i = rt; ret_tid_i = rtid;
    @(posedge clk);
    @(negedge clk);
    stall_i = 0; miss_i = 0; ret_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1ace_b00c;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    ck("R1 vld in reset", 32'(fetch_vld_o), 0);
    ck("R1 flush in reset", 32'(flush_o), 0);
    ck("R1 refill in reset", 32'(refill_o), 0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0);
    // R6/R1: start from reset tries thread 1 first, at its boot address
    ck("R6 first thread", 32'(tid_o), 1);
    ck("R1 boot pc t1", fetch_pc_o, 32'h1100);
    ck("R3 refill open", 32'(refill_o), 1);
    step(0, 1, 32'hdead, 0, 0);            // R3: miss during refill ignored
    ck("R3 miss ignored tid", 32'(tid_o), 1);
    ck("R3 miss ignored flush", 32'(flush_o), 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    ck("R3 refill still 1", 32'(refill_o), 1);
    step(0, 0, 0, 0, 0);
    ck("R3 refill closed after 4", 32'(refill_o), 0);
    ck("R4 pc advanced", fetch_pc_o, 32'h1110);
    step(1, 0, 0, 0, 0);                   // R5
    ck("R5 stall holds pc", fetch_pc_o, 32'h1110);
    ck("R5 stall no switch", 32'(tid_o), 1);
    step(0, 1, 32'h1104, 0, 0);            // R2
    ck("R2 flush pulse", 32'(flush_o), 1);
    ck("R2 switch to t2", 32'(tid_o), 2);
    ck("R1 boot pc t2", fetch_pc_o, 32'h1200);
    step(0, 0, 0, 0, 0);
    ck("R2 flush one cycle", 32'(flush_o), 0);
    repeat (3) step(0, 0, 0, 0, 0);
    thr_en_i = 4'b0111;                    // R9: thread 3 excluded
    step(0, 1, 32'h1208, 1, 2);            // R8: miss and return same thread
    ck("R9 R8 skip t3 pick t0", 32'(tid_o), 0);
    ck("R1 boot pc t0", fetch_pc_o, 32'h1000);
    repeat (4) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);                   // R8: return for running thread
    ck("R8 stray return no effect", 32'(tid_o), 0);
    step(0, 0, 0, 1, 1);
    step(0, 1, 32'h1010, 0, 0);
    ck("R4 resume at miss pc", fetch_pc_o, 32'h1104);
    ck("R6 next is t1", 32'(tid_o), 1);
    repeat (4) step(0, 0, 0, 0, 0);
    step(0, 1, 32'h1110, 0, 0);            // R7: nobody eligible
    ck("R7 bubbles", 32'(fetch_vld_o), 0);
    ck("R7 flush on park", 32'(flush_o), 1);
    step(0, 0, 0, 0, 0);
    ck("R7 still idle", 32'(fetch_vld_o), 0);
    step(0, 0, 0, 1, 2);
    ck("R7 restart", 32'(fetch_vld_o), 1);
    ck("R7 restart no flush", 32'(flush_o), 0);
    ck("R8 R4 t2 resumes", fetch_pc_o, 32'h1208);
    thr_en_i = 4'b1111;
    // Pseudo-random phase; the model compare covers every cycle
    for (int c = 0; c < 4000; c++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[31:26] == 6'd0) thr_en_i = lf[3:0] | 4'b0001;
      step(lf[5:4] == 2'b00, lf[9:7] == 3'b000, {16'h0, lf[25:10]},
           lf[12:10] < 3'd2, lf[14:13]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule